// File: doc/BRIEF.md
# External Bus Arbiter with Stalled-Access Indication

This block decides, cycle by cycle, who owns the external memory bus: the processor core or an outside master that asks for it. While the core owns the bus it may run external accesses, each stretched by a programmable number of wait states. When the outside master raises its request, the block lets any access in flight finish, then turns off the address, data and strobe drivers and grants the bus. While the bus is granted the core is normally halted. In a second mode, the core keeps running from internal memory and only stops when it actually needs the external bus.

A hang output tells the outside world that the core has an external access waiting on a granted bus. Other masters can use it to hand the bus back sooner. The waiting access is launched in the same cycle that the grant is withdrawn. The hang indication stays up until that access has finished. Arbitration is live even while the synchronous reset is held.

Top module: `extbus_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant_o` follows `bus_req_i` with one cycle of delay. No access is active during reset, and writes to the wait-state count are ignored. The wait-state count is 7 on leaving reset.
- R2: With no access active, a request seen at a clock edge gives `grant_o`=1, `drive_en_o`=0 and (in normal mode) `halt_o`=1 in the cycle after that edge.
- R3: A request that arrives while an access is active is not granted until the cycle after the access's last cycle. With 7 wait states, that is up to eight cycles later.
- R4: An access started with wait count W keeps `acc_active_o` high for W+1 cycles. `acc_done_o` is high in the last of those cycles only. `ws_wr_i` loads a 3-bit count from `ws_data_i`. That count is used by the next access to start.
- R5: After each access ends there is one cycle with no access active. A request pending in that cycle wins the bus, even if the core still asserts `ext_need_i` for a second access. Without a request, the second access starts at the edge ending that cycle.
- R6: When `go_mode_i`=1, `halt_o` is high only while the bus is granted and `ext_need_i` is high. When `go_mode_i`=0, `halt_o` equals `grant_o`.
- R7: `hang_o` is high in any cycle where the bus is granted and `ext_need_i` is high. Once raised this way, it stays high until the end of the cycle in which the next access completes.
- R8: When the request is low at a clock edge while granted, the next cycle has `grant_o`=0 and `drive_en_o`=1, and `halt_o` is released. If `ext_need_i` was high at that edge, the access starts in that same next cycle.
- R9: `grant_o` and `acc_active_o` are never high together, and `drive_en_o` is the complement of `grant_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_i | input | 1 | Outside master asks for the bus |
| ext_need_i | input | 1 | Core needs an external access; held until `acc_done_o` |
| go_mode_i | input | 1 | 1 = core keeps running from internal memory while granted |
| ws_wr_i | input | 1 | Load the wait-state count |
| ws_data_i | input | 3 | New wait-state count, 0 to 7 |
| grant_o | output | 1 | Bus granted to the outside master |
| hang_o | output | 1 | Core access stalled behind the grant |
| halt_o | output | 1 | Stop the core |
| drive_en_o | output | 1 | Enable for address, data and strobe drivers |
| acc_active_o | output | 1 | External access in progress |
| acc_done_o | output | 1 | Last cycle of the current access |

## Verification
The hardest case to reach is a stalled access. This needs a request to land while an access is still in its wait states, with the core keeping its need raised past the end of that access. The grant must then win the idle gap, raise the hang flag, and launch the held access on release. The bench creates this case on purpose. It starts an access with the full default wait count and raises the request mid-access. It keeps `ext_need_i` high until `acc_done_o` appears, then drops the request. A randomized phase then mixes requests, needs, mode changes and wait-count writes, checked against a cycle model.

// File: rtl/extbus_arb_pkg.sv
// Package: shared constants for the external bus arbiter.
// Assumes a 3-bit wait-state count; reset value is the slowest setting.
package extbus_arb_pkg;
    localparam int unsigned WS_WIDTH   = 3;
    localparam int unsigned WS_DEFAULT = 7;

    typedef enum logic {
        OWNER_CORE  = 1'b0,
        OWNER_OUTER = 1'b1
    } bus_owner_e;
endpackage

// File: rtl/extbus_ws_reg.sv
// Module: holds the programmable wait-state count.
// Assumes writes arrive as single-cycle strobes; writes during reset are dropped.
module extbus_ws_reg #(
    parameter int unsigned WS_W   = 3,
    parameter int unsigned WS_RST = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [WS_W-1:0] data_i,
    output logic [WS_W-1:0] ws_o
);
    localparam logic [WS_W-1:0] RST_VAL = WS_RST[WS_W-1:0];

    logic [WS_W-1:0] ws_q;

    // Purpose: load the count on a write, restore the slowest setting in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q <= RST_VAL;
        end else if (wr_i) begin
            ws_q <= data_i;
        end
    end

    assign ws_o = ws_q;
endmodule

// File: rtl/extbus_acc_timer.sv
// Module: times one external access of (wait count + 1) cycles.
// Assumes start_i is only raised while no access is active.
module extbus_acc_timer #(
    parameter int unsigned WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [WS_W-1:0] ws_i,
    output logic            busy_o,
    output logic            done_o
);
    logic            busy_q;
    logic [WS_W-1:0] cnt_q;

    // Purpose: load the remaining-wait counter on start, count down, end on zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= ws_i;
        end else if (busy_q && cnt_q == '0) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    // R4: a started access holds the wait count that was presented at start
    a_r4_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_q && cnt_q == $past(ws_i)));

    // R4: an access that has wait cycles left keeps going and counts down by one
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0 && !start_i) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/extbus_hang_track.sv
// Module: remembers a core access that was blocked by a granted bus.
// Assumes the core holds its need until the blocked access completes.
module extbus_hang_track (
    input  logic clk,
    input  logic rst_n,
    input  logic granted_i,
    input  logic need_i,
    input  logic done_i,
    output logic hang_o
);
    logic pend_q;
    logic blocked;

    assign blocked = granted_i && need_i;

    // Purpose: set on a blocked need, clear once the pending access completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (blocked) begin
            pend_q <= 1'b1;
        end else if (done_i) begin
            pend_q <= 1'b0;
        end
    end

    assign hang_o = pend_q || blocked;

    // R7: a blocked need keeps hang raised into the following cycle
    a_r7_hang_held: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> hang_o);

    // R7: hang drops right after the pending access finishes if nothing blocks
    a_r7_hang_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !blocked) |=> (hang_o == (granted_i && need_i)));
endmodule

// File: rtl/extbus_arbiter.sv
// Module: top of the external bus arbiter. Grants the bus to an outside
// master between core accesses, halts the core (or only stalls it in the
// keep-running mode), gates the bus drivers and flags stalled accesses.
// Assumes bus_req_i and ext_need_i are synchronous to clk.
module extbus_arbiter
    import extbus_arb_pkg::*;
#(
    parameter int unsigned WS_W   = WS_WIDTH,
    parameter int unsigned WS_RST = WS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req_i,
    input  logic            ext_need_i,
    input  logic            go_mode_i,
    input  logic            ws_wr_i,
    input  logic [WS_W-1:0] ws_data_i,
    output logic            grant_o,
    output logic            hang_o,
    output logic            halt_o,
    output logic            drive_en_o,
    output logic            acc_active_o,
    output logic            acc_done_o
);
    bus_owner_e      owner_q;
    bus_owner_e      owner_d;
    logic            start;
    logic            busy;
    logic            done;
    logic            granted;
    logic [WS_W-1:0] ws_cur;

    extbus_ws_reg #(.WS_W(WS_W), .WS_RST(WS_RST)) i_ws (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ws_wr_i),
        .data_i (ws_data_i),
        .ws_o   (ws_cur)
    );

    extbus_acc_timer #(.WS_W(WS_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .ws_i    (ws_cur),
        .busy_o  (busy),
        .done_o  (done)
    );

    assign granted = (owner_q == OWNER_OUTER);

    extbus_hang_track i_hang (
        .clk       (clk),
        .rst_n     (rst_n),
        .granted_i (granted),
        .need_i    (ext_need_i),
        .done_i    (done),
        .hang_o    (hang_o)
    );

    // Purpose: pick the next owner and decide whether a core access starts.
    always_comb begin
        owner_d = owner_q;
        start   = 1'b0;
        if (!rst_n) begin
            owner_d = bus_req_i ? OWNER_OUTER : OWNER_CORE;
        end else if (granted) begin
            if (!bus_req_i) begin
                owner_d = OWNER_CORE;
                start   = ext_need_i;
            end
        end else if (busy) begin
            if (done && bus_req_i) begin
                owner_d = OWNER_OUTER;
            end
        end else if (bus_req_i) begin
            owner_d = OWNER_OUTER;
        end else begin
            start = ext_need_i;
        end
    end

    // Purpose: register the bus owner.
    always_ff @(posedge clk) begin
        owner_q <= owner_d;
    end

    assign grant_o      = granted;
    assign drive_en_o   = !granted;
    assign halt_o       = granted && (!go_mode_i || ext_need_i);
    assign acc_active_o = busy;
    assign acc_done_o   = done;

    // R9: the bus is never lent out while a core access is running
    a_r9_no_grant_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && acc_active_o));

    // R2: an idle core hands the bus over in the very next cycle
    a_r2_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_o && !acc_active_o && bus_req_i) |=> (grant_o && !drive_en_o));

    // R3: a request during an access is granted right after the last access cycle
    a_r3_grant_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done_o && bus_req_i) |=> grant_o);

    // R3: no grant appears while an unfinished access is still running
    a_r3_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active_o && !acc_done_o) |=> !grant_o);

    // R8: release returns the drivers and starts a waiting access at once
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !bus_req_i) |=> (!grant_o && drive_en_o && (acc_active_o == $past(ext_need_i))));

    // R6: in keep-running mode the core is only stopped for a blocked need
    a_r6_go_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (go_mode_i && halt_o) |-> (grant_o && ext_need_i));
endmodule

// File: tb/test_extbus_arbiter.sv
module test_extbus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req_i = 1'b0;
    logic       ext_need_i = 1'b0;
    logic       go_mode_i = 1'b0;
    logic       ws_wr_i = 1'b0;
    logic [2:0] ws_data_i = 3'd0;
    logic       grant_o, hang_o, halt_o, drive_en_o, acc_active_o, acc_done_o;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    bit m_grant = 0;
    int m_rem   = 0;
    bit m_pend  = 0;
    int m_ws    = 7;

    extbus_arbiter i_extbus_arbiter (
        .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .ext_need_i(ext_need_i),
        .go_mode_i(go_mode_i), .ws_wr_i(ws_wr_i), .ws_data_i(ws_data_i),
        .grant_o(grant_o), .hang_o(hang_o), .halt_o(halt_o), .drive_en_o(drive_en_o),
        .acc_active_o(acc_active_o), .acc_done_o(acc_done_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: advances on each edge from the inputs seen there
    always @(posedge clk) begin
        bit done;
        done = (m_rem == 1);
        if (!rst_n) begin
            m_grant = bus_req_i;
            m_rem   = 0;
            m_pend  = 0;
            m_ws    = 7;
        end else begin
            if (m_grant && ext_need_i) m_pend = 1;
            else if (done)             m_pend = 0;
            if (m_grant) begin
                if (!bus_req_i) begin
                    m_grant = 0;
                    if (ext_need_i) m_rem = m_ws + 1;
                end
            end else if (m_rem > 1) begin
                m_rem--;
            end else if (m_rem == 1) begin
                m_rem = 0;
                if (bus_req_i) m_grant = 1;
            end else if (bus_req_i) begin
                m_grant = 1;
            end else if (ext_need_i) begin
                m_rem = m_ws + 1;
            end
            if (ws_wr_i) m_ws = ws_data_i;
        end
    end

    // compare every output against the model away from the active edge
    always @(negedge clk) begin
        bit hang_e, halt_e;
        hang_e = m_pend || (m_grant && ext_need_i);
        halt_e = m_grant && (!go_mode_i || ext_need_i);
        chk("R9", "model grant", grant_o, m_grant);
        chk("R9", "model drive", drive_en_o, !m_grant);
        chk("R4", "model active", acc_active_o, m_rem > 0);
        chk("R4", "model done", acc_done_o, m_rem == 1);
        chk("R7", "model hang", hang_o, hang_e);
        chk("R6", "model halt", halt_o, halt_e);
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state, then arbitration alive during reset
        repeat (3) tick();
        chk("R1", "grant in reset", grant_o, 0);
        chk("R1", "drive in reset", drive_en_o, 1);
        bus_req_i = 1; ws_wr_i = 1; ws_data_i = 3'd1;
        tick();
        chk("R1", "grant follows req in reset", grant_o, 1);
        bus_req_i = 0; ws_wr_i = 0;
        tick();
        chk("R1", "grant drops in reset", grant_o, 0);
        rst_n = 1;
        tick();

        // R2 and R8: idle grant, then release
        bus_req_i = 1;
        tick();
        chk("R2", "grant", grant_o, 1);
        chk("R2", "drive", drive_en_o, 0);
        #0 chk("R2", "halt", halt_o, 1);
        tick();
        bus_req_i = 0;
        tick();
        chk("R8", "grant after release", grant_o, 0);
        chk("R8", "drive after release", drive_en_o, 1);
        chk("R8", "halt after release", halt_o, 0);

        // R3 and R1: default 7 waits; request mid-access waits eight cycles
        ext_need_i = 1;
        tick();
        chk("R1", "access starts with default count", acc_active_o, 1);
        bus_req_i = 1;
        n = 0;
        while (!grant_o && n < 20) begin tick(); n++; end
        chk("R3", "cycles until grant", n, 8);
        #1 chk("R7", "hang while need blocked", hang_o, 1);
        chk("R5", "grant won gap despite need", grant_o, 1);
        tick();
        bus_req_i = 0;
        tick();
        chk("R8", "held access starts on release", acc_active_o, 1);
        chk("R7", "hang kept until pending access ends", hang_o, 1);
        while (!acc_done_o) tick();
        ext_need_i = 0;
        tick();
        chk("R7", "hang cleared after access", hang_o, 0);

        // R4: programmed wait counts
        ws_wr_i = 1; ws_data_i = 3'd2;
        tick();
        ws_wr_i = 0; ext_need_i = 1;
        tick();
        n = 1;
        while (!acc_done_o && n < 20) begin tick(); n++; end
        chk("R4", "length with 2 waits", n, 3);
        ext_need_i = 0;
        tick();
        ws_wr_i = 1; ws_data_i = 3'd0;
        tick();
        ws_wr_i = 0; ext_need_i = 1;
        tick();
        chk("R4", "zero-wait done at once", acc_done_o, 1);
        // R5: need still held, no request: one gap cycle then next access
        tick();
        chk("R5", "gap cycle idle", acc_active_o, 0);
        tick();
        chk("R5", "second access starts", acc_active_o, 1);
        ext_need_i = 0;
        tick();

        // R6: keep-running mode
        go_mode_i = 1; bus_req_i = 1;
        tick();
        chk("R6", "granted, core runs", halt_o, 0);
        ext_need_i = 1;
        #1 chk("R6", "halt on blocked need", halt_o, 1);
        tick();
        ext_need_i = 0; bus_req_i = 0;
        tick();
        tick();
        go_mode_i = 0;

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            if (acc_done_o && $urandom_range(0, 1) == 1) ext_need_i = 0;
            else if (!ext_need_i) ext_need_i = ($urandom_range(0, 3) == 0);
            bus_req_i = ($urandom_range(0, 2) == 0) ? ~bus_req_i : bus_req_i;
            go_mode_i = ($urandom_range(0, 50) == 0) ? ~go_mode_i : go_mode_i;
            ws_wr_i   = ($urandom_range(0, 20) == 0);
            ws_data_i = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 400) == 0) rst_n = 0; else rst_n = 1;
            tick();
        end
        tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule